// File: doc/BRIEF.md
# Address Acknowledge Pacer

This block is the central unit that closes address tenures on a processor bus whose address and data phases may be split. It watches the active-low transfer-start strobe and produces the active-low address-acknowledge strobe that ends each address tenure. It also drives the active-low bus grant. Through that grant it paces the masters in two ways. New tenures are spaced at least three cycles apart. The number of tenures that have been acknowledged but whose data has not yet completed is kept below a configured limit.

Each slave reports a busy line. These lines are ORed together, and any busy slave holds the acknowledge back until every slave is ready. Two timing modes are available. In the fast mode the acknowledge comes in the cycle right after the strobe. In the decode mode the slave-select address bits are registered on the strobe and decoded in the next cycle. The acknowledge then comes no earlier than the second cycle after the strobe, together with a one-hot slave select. A strobe that arrives while a tenure is still waiting for its acknowledge, or inside the spacing window, is reported as a protocol error and is never acknowledged.

Top module: `aack_pacer`

## Requirements
- R1: In fast mode (cfg_decode = 0), a transfer start sampled while the unit is free and no slave is busy produces aack_n low in the very next cycle.
- R2: After an accepted transfer start, bg_n is high for the two following cycles, so the next tenure cannot start less than three cycles after the previous one. With br_n low and nothing else blocking, bg_n goes low in the third cycle.
- R3: The outstanding count goes up by one with each acknowledge and down by one with each data_done pulse. It never goes below zero. bg_n stays high while the count is equal to or above cfg_cap.
- R4: If an acknowledge and a data_done pulse fall in the same cycle, the outstanding count does not change.
- R5: While any bit of slave_busy is 1, the pending acknowledge is held back. It is issued in the cycle after the first cycle in which all busy bits are 0.
- R6: In decode mode (cfg_decode = 1), aack_n stays high in the cycle after the transfer start. With no slave busy, it goes low in the second cycle after the transfer start.
- R7: aack_n is a one-cycle low pulse driven from a register. Each accepted transfer start receives exactly one pulse.
- R8: A transfer start sampled while a tenure is still waiting for its acknowledge, or within two cycles after an accepted start, raises proto_err for one cycle in the following cycle. Such a start produces no acknowledge.
- R9: cfg_decode and cfg_cap are taken only while reset is active. Changes made to them after reset have no effect.
- R10: In decode mode, dec_sel carries a one-hot value in the acknowledge cycle. Bit i is set when ts_addr equals i. In every other cycle, and always in fast mode, dec_sel is zero.
- R11: While reset is active, aack_n and bg_n are high and dec_sel and proto_err are zero. After reset, with br_n low and no tenure in flight, bg_n goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_decode | input | 1 | Timing mode: 0 fast, 1 decode-delayed (taken during reset) |
| cfg_cap | input | CW | Outstanding-transfer limit (taken during reset) |
| ts_n | input | 1 | Transfer-start strobe, active low |
| ts_addr | input | $clog2(NS) | Upper address bits that pick the slave |
| slave_busy | input | NS | Busy line of each slave, active high |
| br_n | input | 1 | Bus request, active low |
| data_done | input | 1 | One pulse per completed data tenure |
| aack_n | output | 1 | Address-acknowledge strobe, active low |
| bg_n | output | 1 | Bus grant, active low |
| dec_sel | output | NS | One-hot slave select, valid with the decode-mode acknowledge |
| proto_err | output | 1 | One-cycle pulse for a start that arrives when none is allowed |

## Verification
The bench builds the block with four slaves, a three-bit outstanding counter and three-cycle spacing. It runs the fast mode with a limit of two and the decode mode with a limit of three. The limit of two lets two back-to-back tenures reach the grant withholding. It also makes a same-cycle acknowledge and completion visible at bg_n, because a wrong count would cross the limit. Four slaves let the bench check that busy lines are ORed across different bits and that the one-hot select follows different address values.

// File: rtl/aack_pacer_pkg.sv
package aack_pacer_pkg;

  // Tenure engine states
  typedef enum logic [1:0] {
    TN_IDLE = 2'd0,  // free, may accept a transfer start
    TN_HOLD = 2'd1,  // fast mode, acknowledge held by busy slaves
    TN_DEC  = 2'd2   // decode mode, decode cycle and busy wait
  } tenure_st_e;

endpackage

// File: rtl/aack_rst_sync.sv
module aack_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_o_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_o_n = sh_q[STAGES-1];

endmodule

// File: rtl/aack_tenure_fsm.sv
module aack_tenure_fsm
  import aack_pacer_pkg::*;
#(
  parameter int NS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  decode_mode,
  input  logic                  ts_n,
  input  logic [$clog2(NS)-1:0] ts_addr,
  input  logic [NS-1:0]         slave_busy,
  input  logic                  gap_active,
  output logic                  aack_n,
  output logic [NS-1:0]         dec_sel,
  output logic                  proto_err,
  output logic                  ack_set,
  output logic                  ts_take,
  output logic                  idle_next
);

  localparam int SELW = $clog2(NS);

  tenure_st_e       st_q;
  tenure_st_e       st_d;
  logic [SELW-1:0]  addr_q;
  logic             addr_en;
  logic             busy_any;
  logic             ts_seen;
  logic             perr_d;
  logic             aack_d;
  logic [NS-1:0]    sel_dec;
  logic [NS-1:0]    sel_d;

  assign busy_any = |slave_busy;
  assign ts_seen  = !ts_n;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    ack_set = 1'b0;
    ts_take = 1'b0;
    addr_en = 1'b0;
    unique case (st_q)
      TN_IDLE: begin
        if (ts_seen && !gap_active) begin
          ts_take = 1'b1;
          if (decode_mode) begin
            addr_en = 1'b1;
            st_d    = TN_DEC;
          end else if (busy_any) begin
            st_d = TN_HOLD;
          end else begin
            ack_set = 1'b1;
          end
        end
      end
      TN_HOLD, TN_DEC: begin
        if (!busy_any) begin
          ack_set = 1'b1;
          st_d    = TN_IDLE;
        end
      end
      default: st_d = TN_IDLE;
    endcase
    perr_d = ts_seen && !ts_take;
  end

  // slave decode of the registered address field
  always_comb begin
    sel_dec = '0;
    if (int'(addr_q) < NS) begin
      sel_dec[addr_q] = 1'b1;
    end
  end

  always_comb begin
    sel_d     = (ack_set && decode_mode) ? sel_dec : '0;
    aack_d    = !ack_set;
    idle_next = (st_d == TN_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= TN_IDLE;
      aack_n    <= 1'b1;
      dec_sel   <= '0;
      proto_err <= 1'b0;
    end else begin
      st_q      <= st_d;
      aack_n    <= aack_d;
      dec_sel   <= sel_d;
      proto_err <= perr_d;
    end
  end

  // address register, clock enable only
  always_ff @(posedge clk) begin
    if (addr_en) begin
      addr_q <= ts_addr;
    end
  end

  // R1
  fast_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!decode_mode && ts_take && !busy_any) |=> !aack_n);

  // R6
  dec_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_mode && ts_take) |=> aack_n);

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != TN_IDLE) && busy_any) |=> aack_n);

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aack_n |=> aack_n);

  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!aack_n && decode_mode) |-> $onehot(dec_sel));

  // R10
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aack_n |-> (dec_sel == '0));

  // R8
  err_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_seen && gap_active && (st_q == TN_IDLE)) |=> (aack_n && proto_err));

endmodule

// File: rtl/aack_out_track.sv
module aack_out_track #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  always_comb begin
    cnt_d = cnt_q;
    unique case ({inc, dec})
      2'b10: if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      2'b01: if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R4
  both_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> (cnt_q == $past(cnt_q)));

  // R3
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && dec && !inc) |=> (cnt_q == '0));

endmodule

// File: rtl/aack_grant_ctl.sv
module aack_grant_ctl #(
  parameter int CW      = 3,
  parameter int SPACING = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_n,
  input  logic          ts_take,
  input  logic          idle_next,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cnt_d,
  input  logic [CW-1:0] cap,
  output logic          bg_n,
  output logic          gap_active
);

  localparam int            GW       = $clog2(SPACING);
  localparam logic [GW-1:0] GAP_LOAD = GW'(SPACING - 1);

  logic [GW-1:0] gap_q;
  logic [GW-1:0] gap_d;
  logic          bg_d;

  assign gap_active = (gap_q != '0);

  always_comb begin
    if (ts_take) begin
      gap_d = GAP_LOAD;
    end else if (gap_active) begin
      gap_d = gap_q - 1'b1;
    end else begin
      gap_d = '0;
    end
    bg_d = !(!br_n && idle_next && (gap_d == '0) && (cnt_d < cap));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      bg_n  <= 1'b1;
    end else begin
      gap_q <= gap_d;
      bg_n  <= bg_d;
    end
  end

  // R3
  cap_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bg_n |-> (cnt_q < cap));

  // R2
  gap_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> bg_n);

  // R2
  start_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_take |=> bg_n);

endmodule

// File: rtl/aack_pacer.sv
module aack_pacer #(
  parameter int NS      = 4,
  parameter int CW      = 3,
  parameter int SPACING = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_decode,
  input  logic [CW-1:0]         cfg_cap,
  input  logic                  ts_n,
  input  logic [$clog2(NS)-1:0] ts_addr,
  input  logic [NS-1:0]         slave_busy,
  input  logic                  br_n,
  input  logic                  data_done,
  output logic                  aack_n,
  output logic                  bg_n,
  output logic [NS-1:0]         dec_sel,
  output logic                  proto_err
);

  logic          core_rst_n;
  logic          mode_q;
  logic [CW-1:0] cap_q;
  logic          ack_set;
  logic          ts_take;
  logic          idle_next;
  logic          gap_active;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  aack_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_o_n (core_rst_n)
  );

  // static configuration, loaded only while the core is in reset
  always_ff @(posedge clk) begin
    if (!core_rst_n) begin
      mode_q <= cfg_decode;
      cap_q  <= cfg_cap;
    end
  end

  aack_tenure_fsm #(.NS(NS)) u_fsm (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .decode_mode (mode_q),
    .ts_n        (ts_n),
    .ts_addr     (ts_addr),
    .slave_busy  (slave_busy),
    .gap_active  (gap_active),
    .aack_n      (aack_n),
    .dec_sel     (dec_sel),
    .proto_err   (proto_err),
    .ack_set     (ack_set),
    .ts_take     (ts_take),
    .idle_next   (idle_next)
  );

  aack_out_track #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (core_rst_n),
    .inc   (ack_set),
    .dec   (data_done),
    .cnt_q (cnt_q),
    .cnt_d (cnt_d)
  );

  aack_grant_ctl #(.CW(CW), .SPACING(SPACING)) u_gnt (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .br_n       (br_n),
    .ts_take    (ts_take),
    .idle_next  (idle_next),
    .cnt_q      (cnt_q),
    .cnt_d      (cnt_d),
    .cap        (cap_q),
    .bg_n       (bg_n),
    .gap_active (gap_active)
  );

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cfg_decode != mode_q) |=> (mode_q == $past(mode_q)));

  // R11
  rst_quiet_chk: assert property (@(posedge clk)
    !core_rst_n |=> (!core_rst_n || (aack_n && !proto_err)));

endmodule

// File: tb/sim_aack_pacer.sv
module sim_aack_pacer;

  localparam int NS = 4;
  localparam int CW = 3;

  logic          clk;
  logic          rst_n;
  logic          cfg_decode;
  logic [CW-1:0] cfg_cap;
  logic          ts_n;
  logic [1:0]    ts_addr;
  logic [NS-1:0] slave_busy;
  logic          br_n;
  logic          data_done;
  logic          aack_n;
  logic          bg_n;
  logic [NS-1:0] dec_sel;
  logic          proto_err;

  int checks;
  int errors;
  bit finished;

  aack_pacer #(.NS(NS), .CW(CW), .SPACING(3)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_decode (cfg_decode),
    .cfg_cap    (cfg_cap),
    .ts_n       (ts_n),
    .ts_addr    (ts_addr),
    .slave_busy (slave_busy),
    .br_n       (br_n),
    .data_done  (data_done),
    .aack_n     (aack_n),
    .bg_n       (bg_n),
    .dec_sel    (dec_sel),
    .proto_err  (proto_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      data_done = 1'b1;
      step();
      data_done = 1'b0;
    end
  endtask

  task automatic do_reset(input logic mode, input logic [CW-1:0] cap);
    rst_n      = 1'b0;
    cfg_decode = mode;
    cfg_cap    = cap;
    repeat (4) step();
    chk("R11 aack_n in reset", aack_n, 1'b1);
    chk("R11 bg_n in reset", bg_n, 1'b1);
    chk("R11 dec_sel in reset", dec_sel, 4'b0000);
    chk("R11 proto_err in reset", proto_err, 1'b0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R11 grant after reset", bg_n, 1'b0);
  endtask

  task automatic t_fast();
    ts_addr = 2'b11;
    ts_n    = 1'b0;
    step();
    chk("R1 fast ack next cycle", aack_n, 1'b0);
    chk("R10 dec_sel zero in fast mode", dec_sel, 4'b0000);
    chk("R2 grant dropped after start", bg_n, 1'b1);
    ts_n = 1'b1;
    step();
    chk("R7 ack one cycle", aack_n, 1'b1);
    chk("R2 grant still withheld", bg_n, 1'b1);
    step();
    chk("R2 grant back in third cycle", bg_n, 1'b0);
  endtask

  task automatic t_cap();
    // count is 1, cap is 2
    ts_n = 1'b0;
    step();
    chk("R1 second ack", aack_n, 1'b0);
    ts_n = 1'b1;
    step();
    step();
    chk("R3 grant withheld at cap", bg_n, 1'b1);
    step();
    chk("R3 grant still withheld at cap", bg_n, 1'b1);
    data_done = 1'b1;
    step();
    data_done = 1'b0;
    chk("R3 grant after completion", bg_n, 1'b0);
    ts_n      = 1'b0;
    data_done = 1'b1;
    step();
    chk("R4 ack with completion", aack_n, 1'b0);
    ts_n      = 1'b1;
    data_done = 1'b0;
    step();
    step();
    chk("R4 count unchanged keeps grant", bg_n, 1'b0);
    drain(1);
  endtask

  task automatic t_busy();
    slave_busy = 4'b0100;
    ts_n       = 1'b0;
    step();
    chk("R5 ack held by busy", aack_n, 1'b1);
    ts_n       = 1'b1;
    slave_busy = 4'b0010;
    step();
    chk("R5 ack held by other busy", aack_n, 1'b1);
    step();
    chk("R5 ack still held", aack_n, 1'b1);
    slave_busy = 4'b0000;
    step();
    chk("R5 ack after busy clears", aack_n, 1'b0);
    step();
    chk("R7 single ack after hold", aack_n, 1'b1);
    drain(1);
  endtask

  task automatic t_proto();
    slave_busy = 4'b0001;
    ts_n       = 1'b0;
    step();
    chk("R5 held before second start", aack_n, 1'b1);
    step();
    chk("R8 error on start while pending", proto_err, 1'b1);
    chk("R8 no ack for bad start", aack_n, 1'b1);
    ts_n       = 1'b1;
    slave_busy = 4'b0000;
    step();
    chk("R8 error is one cycle", proto_err, 1'b0);
    chk("R7 pending tenure acked", aack_n, 1'b0);
    step();
    chk("R7 no second ack", aack_n, 1'b1);
    step();
    step();
    ts_n = 1'b0;
    step();
    chk("R1 ack before window test", aack_n, 1'b0);
    step();
    chk("R8 error inside spacing window", proto_err, 1'b1);
    chk("R8 no ack inside window", aack_n, 1'b1);
    ts_n = 1'b1;
    step();
    chk("R8 still no ack", aack_n, 1'b1);
    step();
    drain(2);
  endtask

  task automatic t_cfg();
    cfg_decode = 1'b1;
    cfg_cap    = 3'd0;
    ts_n       = 1'b0;
    step();
    chk("R9 mode change ignored", aack_n, 1'b0);
    ts_n = 1'b1;
    step();
    step();
    chk("R9 cap change ignored", bg_n, 1'b0);
    cfg_decode = 1'b0;
    cfg_cap    = 3'd2;
    drain(1);
  endtask

  task automatic t_decode();
    ts_addr = 2'b10;
    ts_n    = 1'b0;
    step();
    chk("R6 no ack in decode cycle", aack_n, 1'b1);
    chk("R10 dec_sel zero before ack", dec_sel, 4'b0000);
    ts_n = 1'b1;
    step();
    chk("R6 ack in second cycle", aack_n, 1'b0);
    chk("R10 one-hot slave 2", dec_sel, 4'b0100);
    step();
    chk("R7 decode ack one cycle", aack_n, 1'b1);
    chk("R10 dec_sel cleared", dec_sel, 4'b0000);
    step();
    ts_addr    = 2'b11;
    slave_busy = 4'b1000;
    ts_n       = 1'b0;
    step();
    ts_n = 1'b1;
    step();
    chk("R5 decode ack held by busy", aack_n, 1'b1);
    slave_busy = 4'b0000;
    step();
    chk("R6 decode ack after busy", aack_n, 1'b0);
    chk("R10 one-hot slave 3", dec_sel, 4'b1000);
    step();
    chk("R7 decode ack ends", aack_n, 1'b1);
  endtask

  initial begin
    checks     = 0;
    errors     = 0;
    finished   = 1'b0;
    ts_n       = 1'b1;
    ts_addr    = 2'b00;
    slave_busy = 4'b0000;
    br_n       = 1'b0;
    data_done  = 1'b0;
    do_reset(1'b0, 3'd2);
    t_fast();
    t_cap();
    t_busy();
    t_proto();
    t_cfg();
    do_reset(1'b1, 3'd3);
    t_decode();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule